// File: doc/BRIEF.md
# Ingress Frame Priority Classifier

This block assigns each received frame of a five-port Ethernet switch to the high or the low priority class. An upstream parser has already pulled out the header fields. For each frame it presents the ingress port, a tagged flag with the 3-bit user priority from the VLAN tag, an IPv4 flag with the 6-bit DSCP value, and a one-cycle valid strobe. The block answers one clock later with a done strobe and a one-bit class.

Three sources can vote for high priority. The first is a 64-entry DSCP bitmap indexed by the DSCP value. The second is an 8-entry bitmap indexed by the tag's user priority. The third is a port-level override that makes all traffic from that port high priority. Both bitmaps are global and shared by every port. Each source is switched on or off separately for each port. The winner is picked by a fixed precedence of override, then DSCP, then user priority. A frame is high priority as soon as any enabled source votes high. Configuration is read from plain inputs on the same cycle as valid, so it can be changed freely between frames.

Top module: `prio_classifier`

## Requirements
- R1: While rst_n is low and after it is released, out_done and out_high are 0 until the first frame is presented.
- R2: out_done is 1 in exactly the cycle after each cycle in which in_valid is 1, and 0 in every other cycle.
- R3: When in_ipv4 is 1 and bit in_port of cfg_dscp_en is 1, the frame is high priority if bit in_dscp of cfg_dscp_map is 1 (bit 0 = DSCP 0, bit 63 = DSCP 63).
- R4: The DSCP map has no effect on a frame whose in_ipv4 is 0 or whose port has its cfg_dscp_en bit clear.
- R5: When in_tagged is 1 and bit in_port of cfg_pcp_en is 1, the frame is high priority if bit in_pcp of cfg_pcp_map is 1 (bit 0 = user priority 0).
- R6: The user-priority map has no effect on a frame whose in_tagged is 0 or whose port has its cfg_pcp_en bit clear.
- R7: A frame from a port whose cfg_port_hi bit is 1 is high priority, whatever its fields and maps hold.
- R8: A frame for which no enabled source votes high is low priority (out_high = 0).
- R9: A frame whose in_port is NUM_PORTS or above matches no port and is low priority.
- R10: The result uses only the configuration and fields present in the valid cycle. out_high holds its value, unaffected by later input changes, until the next done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Frame fields are present this cycle |
| in_port | input | PORT_W (3) | Ingress port index, 0 to NUM_PORTS-1 |
| in_tagged | input | 1 | Frame carries a VLAN tag |
| in_pcp | input | 3 | User priority from the tag |
| in_ipv4 | input | 1 | Frame carries an IPv4 header |
| in_dscp | input | 6 | DSCP value from the IPv4 header |
| cfg_dscp_en | input | NUM_PORTS (5) | Per-port enable of DSCP classification |
| cfg_pcp_en | input | NUM_PORTS (5) | Per-port enable of user-priority classification |
| cfg_port_hi | input | NUM_PORTS (5) | Per-port override to high priority |
| cfg_pcp_map | input | 8 | Global user-priority high map |
| cfg_dscp_map | input | 64 | Global DSCP high map |
| out_done | output | 1 | Result valid strobe |
| out_high | output | 1 | 1 = high priority, 0 = low |

## Verification
The bench sweeps every port index, including the three unused codes, against every combination of the three per-port enables, both flags, every user priority and DSCP values at both ends and at the middle of the map. Two map patterns and their complements are used. The other ports get the opposite enable values, so a design that reads the wrong port's enable bit returns the wrong class. Ignoring a flag, or indexing the map off by one, shows as a wrong class on a large share of the frames. Right after each valid cycle the bench flips every configuration input. A design that samples its configuration late, or lets out_high follow the inputs between frames, then reports the wrong class or changes its output without a done strobe.

// File: rtl/pc_pkg.sv
// Package: shared types for the priority classifier.
// Assumes: one classification per frame, three per-port enable bits.
package pc_pkg;

    // Per-port enables after selection by ingress port.
    typedef struct packed {
        logic dscp_en;
        logic pcp_en;
        logic port_hi;
    } port_cfg_t;

    // Which source decided the class, in precedence order.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PORT = 2'd1,
        SRC_DSCP = 2'd2,
        SRC_PCP  = 2'd3
    } prio_src_t;

endpackage

// File: rtl/pc_bitmap_lookup.sv
// Module: fully decoded bitmap lookup.
// Returns the map bit selected by the index. Combinational.
// Assumes: the map has exactly 2**IDX_W entries.
module pc_bitmap_lookup #(
    parameter int IDX_W = 6,
    localparam int MAP_N = 1 << IDX_W
) (
    input  logic [MAP_N-1:0] map,
    input  logic [IDX_W-1:0] idx,
    output logic             hit
);

    // Select the entry addressed by the index.
    always_comb begin
        hit = map[idx];
    end

endmodule

// File: rtl/pc_port_cfg_select.sv
// Module: per-port enable selection.
// Picks the three enable bits belonging to the ingress port.
// Assumes: an index at or above NUM_PORTS matches no port, so all
// enables read as zero.
module pc_port_cfg_select
    import pc_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int PORT_W    = 3
) (
    input  logic [PORT_W-1:0]    port,
    input  logic [NUM_PORTS-1:0] dscp_en,
    input  logic [NUM_PORTS-1:0] pcp_en,
    input  logic [NUM_PORTS-1:0] port_hi,
    output port_cfg_t            sel
);

    logic [NUM_PORTS-1:0] match;

    // Build a one-hot match vector with one comparator per port.
    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_match
        assign match[gi] = (port == PORT_W'(gi));
    end

    // Reduce the masked enable vectors to single bits.
    always_comb begin
        sel.dscp_en = |(match & dscp_en);
        sel.pcp_en  = |(match & pcp_en);
        sel.port_hi = |(match & port_hi);
    end

endmodule

// File: rtl/pc_decide.sv
// Module: source precedence and class decision.
// Applies the fixed order override, DSCP, user priority. Any
// enabled source voting high makes the frame high priority.
// Assumes: the map hits are already looked up for this frame.
module pc_decide
    import pc_pkg::*;
(
    input  port_cfg_t cfg,
    input  logic      is_ipv4,
    input  logic      is_tagged,
    input  logic      dscp_hit,
    input  logic      pcp_hit,
    output logic      high
);

    prio_src_t src;

    // Choose the winning source by fixed precedence.
    always_comb begin
        if (cfg.port_hi)
            src = SRC_PORT;
        else if (cfg.dscp_en && is_ipv4 && dscp_hit)
            src = SRC_DSCP;
        else if (cfg.pcp_en && is_tagged && pcp_hit)
            src = SRC_PCP;
        else
            src = SRC_NONE;
    end

    // Any winner means high priority.
    always_comb begin
        high = (src != SRC_NONE);
    end

endmodule

// File: rtl/pc_result_reg.sv
// Module: output register.
// Registers the done strobe every cycle. Loads the class only on
// valid, so it holds between frames.
// Assumes: synchronous active-low reset.
module pc_result_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic high_d,
    output logic done,
    output logic high_q
);

    // Delay the valid strobe by one cycle to form done.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else
            done <= valid;
    end

    // Capture the class in the valid cycle and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            high_q <= 1'b0;
        else if (valid)
            high_q <= high_d;
    end

endmodule

// File: rtl/prio_classifier.sv
// Module: ingress frame priority classifier (top).
// Classifies each frame as high or low priority from its DSCP value,
// its tag user priority and its ingress port. The result appears one
// cycle after valid.
// Assumes: header fields are already extracted; configuration is
// stable in the valid cycle.
module prio_classifier
    import pc_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int PORT_W    = $clog2(NUM_PORTS),
    parameter int DSCP_W    = 6,
    parameter int PCP_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [PORT_W-1:0]      in_port,
    input  logic                   in_tagged,
    input  logic [PCP_W-1:0]       in_pcp,
    input  logic                   in_ipv4,
    input  logic [DSCP_W-1:0]      in_dscp,
    input  logic [NUM_PORTS-1:0]   cfg_dscp_en,
    input  logic [NUM_PORTS-1:0]   cfg_pcp_en,
    input  logic [NUM_PORTS-1:0]   cfg_port_hi,
    input  logic [(1<<PCP_W)-1:0]  cfg_pcp_map,
    input  logic [(1<<DSCP_W)-1:0] cfg_dscp_map,
    output logic                   out_done,
    output logic                   out_high
);

    port_cfg_t port_cfg;
    logic      dscp_hit;
    logic      pcp_hit;
    logic      high_d;

    pc_port_cfg_select #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W)
    ) u_sel (
        .port    (in_port),
        .dscp_en (cfg_dscp_en),
        .pcp_en  (cfg_pcp_en),
        .port_hi (cfg_port_hi),
        .sel     (port_cfg)
    );

    pc_bitmap_lookup #(.IDX_W(DSCP_W)) u_dscp_lu (
        .map (cfg_dscp_map),
        .idx (in_dscp),
        .hit (dscp_hit)
    );

    pc_bitmap_lookup #(.IDX_W(PCP_W)) u_pcp_lu (
        .map (cfg_pcp_map),
        .idx (in_pcp),
        .hit (pcp_hit)
    );

    pc_decide u_dec (
        .cfg       (port_cfg),
        .is_ipv4   (in_ipv4),
        .is_tagged (in_tagged),
        .dscp_hit  (dscp_hit),
        .pcp_hit   (pcp_hit),
        .high      (high_d)
    );

    pc_result_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (in_valid),
        .high_d (high_d),
        .done   (out_done),
        .high_q (out_high)
    );

endmodule

// File: rtl/pc_checker.sv
// Module: assertion checker, bound to the classifier top.
// Assumes: same parameters as the bound instance.
module pc_checker #(
    parameter int NUM_PORTS = 5,
    parameter int PORT_W    = 3,
    parameter int DSCP_W    = 6,
    parameter int PCP_W     = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [PORT_W-1:0]      in_port,
    input logic                   in_tagged,
    input logic [PCP_W-1:0]       in_pcp,
    input logic                   in_ipv4,
    input logic [DSCP_W-1:0]      in_dscp,
    input logic [NUM_PORTS-1:0]   cfg_dscp_en,
    input logic [NUM_PORTS-1:0]   cfg_pcp_en,
    input logic [NUM_PORTS-1:0]   cfg_port_hi,
    input logic [(1<<PCP_W)-1:0]  cfg_pcp_map,
    input logic [(1<<DSCP_W)-1:0] cfg_dscp_map,
    input logic                   out_done,
    input logic                   out_high
);

    logic [NUM_PORTS-1:0]   de_sh, pe_sh, ph_sh;
    logic [(1<<DSCP_W)-1:0] dm_sh;
    logic [(1<<PCP_W)-1:0]  pm_sh;
    logic port_ok, dscp_vote, pcp_vote;

    // Recompute the per-frame votes by shifting rather than decoding.
    always_comb begin
        de_sh     = cfg_dscp_en >> in_port;
        pe_sh     = cfg_pcp_en >> in_port;
        ph_sh     = cfg_port_hi >> in_port;
        dm_sh     = cfg_dscp_map >> in_dscp;
        pm_sh     = cfg_pcp_map >> in_pcp;
        port_ok   = (32'(in_port) < NUM_PORTS);
        dscp_vote = in_ipv4 && de_sh[0] && dm_sh[0];
        pcp_vote  = in_tagged && pe_sh[0] && pm_sh[0];
    end

    a_r2_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_done);

    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_done);

    a_r3_dscp_high: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && port_ok && dscp_vote) |=> out_high);

    a_r5_pcp_high: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && port_ok && pcp_vote) |=> out_high);

    a_r7_port_override: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && port_ok && ph_sh[0]) |=> out_high);

    a_r8_default_low: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && port_ok && !ph_sh[0] && !dscp_vote && !pcp_vote) |=> !out_high);

    a_r9_bad_port_low: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !port_ok) |=> !out_high);

    a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_high));

endmodule

bind prio_classifier pc_checker #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W),
    .DSCP_W    (DSCP_W),
    .PCP_W     (PCP_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_port      (in_port),
    .in_tagged    (in_tagged),
    .in_pcp       (in_pcp),
    .in_ipv4      (in_ipv4),
    .in_dscp      (in_dscp),
    .cfg_dscp_en  (cfg_dscp_en),
    .cfg_pcp_en   (cfg_pcp_en),
    .cfg_port_hi  (cfg_port_hi),
    .cfg_pcp_map  (cfg_pcp_map),
    .cfg_dscp_map (cfg_dscp_map),
    .out_done     (out_done),
    .out_high     (out_high)
);

// File: tb/tb_prio_classifier.sv
module tb_prio_classifier;

    localparam int NP = 5;
    localparam int PW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_port = '0;
    logic        in_tagged = 1'b0;
    logic [2:0]  in_pcp = '0;
    logic        in_ipv4 = 1'b0;
    logic [5:0]  in_dscp = '0;
    logic [4:0]  cfg_dscp_en = '0;
    logic [4:0]  cfg_pcp_en = '0;
    logic [4:0]  cfg_port_hi = '0;
    logic [7:0]  cfg_pcp_map = '0;
    logic [63:0] cfg_dscp_map = '0;
    logic        out_done;
    logic        out_high;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    prio_classifier #(.NUM_PORTS(NP), .PORT_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_port(in_port),
        .in_tagged(in_tagged), .in_pcp(in_pcp), .in_ipv4(in_ipv4),
        .in_dscp(in_dscp), .cfg_dscp_en(cfg_dscp_en), .cfg_pcp_en(cfg_pcp_en),
        .cfg_port_hi(cfg_port_hi), .cfg_pcp_map(cfg_pcp_map),
        .cfg_dscp_map(cfg_dscp_map), .out_done(out_done), .out_high(out_high)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b (port=%0d tag=%0b pcp=%0d ip=%0b dscp=%0d)",
                     req, act, exp, in_port, in_tagged, in_pcp, in_ipv4, in_dscp);
        end
    endtask

    initial begin
        int dl[6];
        dl = '{0, 1, 31, 32, 62, 63};
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 done in reset", out_done, 1'b0);
        check("R1 high in reset", out_high, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", out_done, 1'b0);
        check("R1 high after reset", out_high, 1'b0);

        for (int mi = 0; mi < 2; mi++) begin
            for (int p = 0; p < 8; p++) begin
                for (int e = 0; e < 8; e++) begin
                    for (int fl = 0; fl < 4; fl++) begin
                        for (int pc = 0; pc < 8; pc++) begin
                            for (int di = 0; di < 6; di++) begin
                                logic [63:0] dmap;
                                logic [7:0]  pmap;
                                logic de, pe, ph, tg, ip, pv, dh, ph_hit, exp;
                                string req;
                                dmap = (mi == 0) ? 64'hA5C3_0F96_1E2D_B487 : ~64'hA5C3_0F96_1E2D_B487;
                                pmap = (mi == 0) ? 8'b1010_0110 : 8'b0101_1001;
                                de = e[0]; pe = e[1]; ph = e[2];
                                tg = fl[0]; ip = fl[1];
                                pv = (p < NP);
                                dh = dmap[dl[di]];
                                ph_hit = pmap[pc];
                                // Other ports get the opposite enables.
                                for (int q = 0; q < NP; q++) begin
                                    cfg_dscp_en[q] = (q == p) ? de : ~de;
                                    cfg_pcp_en[q]  = (q == p) ? pe : ~pe;
                                    cfg_port_hi[q] = (q == p) ? ph : ~ph;
                                end
                                cfg_dscp_map = dmap;
                                cfg_pcp_map  = pmap;
                                in_port   = 3'(p);
                                in_tagged = tg;
                                in_ipv4   = ip;
                                in_pcp    = 3'(pc);
                                in_dscp   = 6'(dl[di]);
                                in_valid  = 1'b1;
                                exp = pv && (ph || (ip && de && dh) || (tg && pe && ph_hit));
                                if (!pv) req = "R9";
                                else if (ph) req = "R7";
                                else if (ip && de && dh) req = "R3";
                                else if (tg && pe && ph_hit) req = "R5";
                                else if (dh) req = "R4";
                                else if (ph_hit) req = "R6";
                                else req = "R8";
                                @(negedge clk);
                                // R10: disturb every input after the valid cycle
                                in_valid = 1'b0;
                                cfg_dscp_en = ~cfg_dscp_en;
                                cfg_pcp_en = ~cfg_pcp_en;
                                cfg_port_hi = ~cfg_port_hi;
                                cfg_dscp_map = ~cfg_dscp_map;
                                cfg_pcp_map = ~cfg_pcp_map;
                                in_tagged = ~in_tagged;
                                in_ipv4 = ~in_ipv4;
                                in_dscp = ~in_dscp;
                                in_pcp = ~in_pcp;
                                check("R2 done strobe", out_done, 1'b1);
                                check(req, out_high, exp);
                                @(negedge clk);
                                check("R2 done one cycle only", out_done, 1'b0);
                                check("R10 class held", out_high, exp);
                            end
                        end
                    end
                end
            end
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule